// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Show-Ahead Output

This block is a first-in first-out buffer working in one clock domain. Words are stored in an inferred two-port RAM array. One port takes writes and the other feeds a registered read-data output. Two compile-time switches shape the read side. `SHOW_AHEAD` selects the output style. When it is 0 (normal), a word appears on `rd_data` only after it is requested. When it is 1 (show-ahead), the head word already sits on `rd_data` whenever `empty` is low. `OUT_REG` models an extra register on the memory output. It adds one cycle to the point where a newly written word becomes visible, which trades latency for shorter paths.

The status outputs are `full`, `empty` and the stored-word count `used_words`. Each follows a fixed cycle latency set by the two switches. A synchronous `clr` input empties the buffer in one cycle. A write while `full` is high is dropped, and so is a read while `empty` is high. `DEPTH` must be a power of two. `used_words` is one bit wider than the address, so the value `DEPTH` can be shown.

Top module: `la_fifo`

## Requirements
- R1: `used_words` (width log2(DEPTH)+1) equals the number of stored words. It changes by at most one per cycle and reflects a write or read accepted in cycle c at cycle c+1.
- R2: `full` is high exactly when `used_words` equals `DEPTH`, and it follows an accepted request by one cycle.
- R3: With SHOW_AHEAD=0 and OUT_REG=1, a write into a buffer showing empty drops `empty` two cycles after the write. A read of the last visible word raises `empty` one cycle after the read.
- R4: With SHOW_AHEAD=0 and OUT_REG=0, `empty` responds one cycle after a write or a read.
- R5: With SHOW_AHEAD=1 and OUT_REG=1, a word written into a buffer showing empty appears on `rd_data` three cycles after the write, as `empty` falls. A read raises `empty` one cycle after it when no visible word remains.
- R6: With SHOW_AHEAD=1 and OUT_REG=0, the same happens two cycles after the write, and `empty` follows a read by one cycle.
- R7: In normal mode, a read accepted in cycle c places the popped word on `rd_data` in cycle c+1. In show-ahead mode, the next head word is on `rd_data` in cycle c+1 whenever `empty` is low.
- R8: Words leave in the order they were accepted. In show-ahead mode, `rd_data` equals the oldest stored word whenever `empty` is low.
- R9: A write while `full` is high is ignored: count, pointers and stored words are unchanged.
- R10: A read while `empty` is high is ignored: count, pointers and `rd_data` are unchanged.
- R11: `clr` high in cycle c gives `empty`=1, `full`=0, `used_words`=0 and `rd_data`=0 in cycle c+1. Requests in cycle c are dropped.
- R12: After reset, `empty`=1, `full`=0, `used_words`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous flush |
| wr_req | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| rd_req | input | 1 | Read request |
| rd_data | output | DATA_W | Read data / head word in show-ahead mode |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | No word visible for reading |
| used_words | output | log2(DEPTH)+1 | Stored-word count |

## Verification
The bound checker watches, on every cycle, that `full` matches a count of `DEPTH`, that the count moves by at most one, that a dropped write or read leaves the count alone, that a visible word implies a non-zero count, that the last read raises `empty` at once, and that a flush takes effect in one cycle. The mode-specific delay before a new word becomes visible, the word values on `rd_data`, and their order can only be shown by the bench's scenarios. The bench runs all four configurations side by side against a reference model with the same stimulus.

// File: rtl/la_fifo_pkg.sv
package la_fifo_pkg;

  // Cycles a freshly written word waits before it is counted as readable.
  // Each option adds one stage between the RAM write and the visible flag.
  function automatic int ready_lat(input bit show_ahead, input bit out_reg);
    return int'(show_ahead) + int'(out_reg);
  endfunction

endpackage

// File: rtl/la_fifo_rst_sync.sv
module la_fifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/la_fifo_mem.sv
module la_fifo_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_ce,
  input  logic              rd_clr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rd_data_q;

  // Storage array: no reset, write port only.
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // Registered read port with its own clock enable and flush.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data_q <= '0;
    else if (rd_clr) rd_data_q <= '0;
    else if (rd_ce)  rd_data_q <= store[rd_addr];
  end

  assign rd_data = rd_data_q;

endmodule

// File: rtl/la_fifo_ctrl.sv
module la_fifo_ctrl #(
  parameter int DEPTH      = 8,
  parameter bit SHOW_AHEAD = 1'b1,
  parameter bit OUT_REG    = 1'b1,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int USED_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_req,
  input  logic              rd_req,
  output logic              wr_en,
  output logic              rd_en,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [ADDR_W-1:0] rd_ptr_nxt,
  output logic              rdy_nz_nxt,
  output logic              full,
  output logic              empty,
  output logic [USED_W-1:0] used
);

  localparam int LAT = la_fifo_pkg::ready_lat(SHOW_AHEAD, OUT_REG);

  logic [ADDR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [USED_W-1:0] cnt_q, cnt_d, rdy_q, rdy_d;
  logic              full_q, full_d, empty_q, empty_d;
  logic              wr_rdy;

  // Requests are accepted against the flags the outside world sees.
  assign wr_en = wr_req & ~full_q  & ~clr;
  assign rd_en = rd_req & ~empty_q & ~clr;

  // Delay line that marks when an accepted write becomes readable.
  generate
    if (LAT == 0) begin : g_rdy_direct
      assign wr_rdy = wr_en;
    end else begin : g_rdy_pipe
      logic [LAT-1:0] pipe_q, pipe_d;
      always_comb begin
        pipe_d    = pipe_q;
        pipe_d[0] = wr_en;
        for (int j = 1; j < LAT; j++) pipe_d[j] = pipe_q[j-1];
        if (clr) pipe_d = '0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
      end
      assign wr_rdy = pipe_q[LAT-1];
    end
  endgenerate

  // Next-state logic.
  always_comb begin
    wr_ptr_d = wr_en ? wr_ptr_q + ADDR_W'(1) : wr_ptr_q;
    rd_ptr_d = rd_en ? rd_ptr_q + ADDR_W'(1) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (wr_en)  cnt_d = cnt_d + USED_W'(1);
    if (rd_en)  cnt_d = cnt_d - USED_W'(1);
    rdy_d    = rdy_q;
    if (wr_rdy) rdy_d = rdy_d + USED_W'(1);
    if (rd_en)  rdy_d = rdy_d - USED_W'(1);
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
      rdy_d    = '0;
    end
    full_d  = (cnt_d == USED_W'(DEPTH));
    empty_d = (rdy_d == '0);
  end

  // State registers with explicit enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      rdy_q    <= '0;
      full_q   <= 1'b0;
      empty_q  <= 1'b1;
    end else begin
      if (wr_en | clr)                   wr_ptr_q <= wr_ptr_d;
      if (rd_en | clr)                   rd_ptr_q <= rd_ptr_d;
      if (wr_en | rd_en | clr)           cnt_q    <= cnt_d;
      if (wr_rdy | rd_en | clr)          rdy_q    <= rdy_d;
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  assign wr_ptr     = wr_ptr_q;
  assign rd_ptr     = rd_ptr_q;
  assign rd_ptr_nxt = rd_ptr_d;
  assign rdy_nz_nxt = (rdy_d != '0);
  assign full       = full_q;
  assign empty      = empty_q;
  assign used       = cnt_q;

endmodule

// File: rtl/la_fifo_rdsel.sv
module la_fifo_rdsel #(
  parameter int ADDR_W     = 3,
  parameter bit SHOW_AHEAD = 1'b1
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_ptr,
  input  logic [ADDR_W-1:0] rd_ptr_nxt,
  input  logic              rdy_nz_nxt,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ce
);

  // Normal: load only the word being popped.
  // Show-ahead: keep reloading the word that will be the head next cycle,
  // and hold the output while nothing readable remains.
  assign rd_addr = SHOW_AHEAD ? rd_ptr_nxt : rd_ptr;
  assign rd_ce   = SHOW_AHEAD ? rdy_nz_nxt : rd_en;

endmodule

// File: rtl/la_fifo.sv
module la_fifo #(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 8,
  parameter bit SHOW_AHEAD = 1'b1,
  parameter bit OUT_REG    = 1'b1,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int USED_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic [USED_W-1:0] used_words
);

  logic              rst_int_n;
  logic              wr_en, rd_en, rdy_nz_nxt, rd_ce;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr, rd_ptr_nxt, rd_addr;

  la_fifo_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  la_fifo_ctrl #(
    .DEPTH      (DEPTH),
    .SHOW_AHEAD (SHOW_AHEAD),
    .OUT_REG    (OUT_REG)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr        (clr),
    .wr_req     (wr_req),
    .rd_req     (rd_req),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .rd_ptr_nxt (rd_ptr_nxt),
    .rdy_nz_nxt (rdy_nz_nxt),
    .full       (full),
    .empty      (empty),
    .used       (used_words)
  );

  la_fifo_rdsel #(
    .ADDR_W     (ADDR_W),
    .SHOW_AHEAD (SHOW_AHEAD)
  ) u_rdsel (
    .rd_en      (rd_en),
    .rd_ptr     (rd_ptr),
    .rd_ptr_nxt (rd_ptr_nxt),
    .rdy_nz_nxt (rdy_nz_nxt),
    .rd_addr    (rd_addr),
    .rd_ce      (rd_ce)
  );

  la_fifo_mem #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_mem (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_ptr),
    .wr_data (wr_data),
    .rd_ce   (rd_ce),
    .rd_clr  (clr),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/la_fifo_chk.sv
module la_fifo_chk #(
  parameter int DEPTH  = 8,
  parameter int USED_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              wr_req,
  input logic              rd_req,
  input logic              full,
  input logic              empty,
  input logic [USED_W-1:0] used_words
);

  AST_FULL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    full == (used_words == USED_W'(DEPTH)));                               // R2

  AST_USED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (used_words == $past(used_words)) ||
             (used_words == $past(used_words) + USED_W'(1)) ||
             (used_words + USED_W'(1) == $past(used_words)));              // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_req && !rd_req && !clr |=> used_words == USED_W'(DEPTH));   // R9

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_req && !wr_req && !clr |=> $stable(used_words));           // R10

  AST_VISIBLE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> used_words != '0);                                          // R1

  AST_LAST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !empty && rd_req && !wr_req && !clr && used_words == USED_W'(1)
    |=> empty);                                                            // R4

  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty && !full && used_words == '0);                           // R11

endmodule

bind la_fifo la_fifo_chk #(
  .DEPTH  (DEPTH),
  .USED_W (USED_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .wr_req     (wr_req),
  .rd_req     (rd_req),
  .full       (full),
  .empty      (empty),
  .used_words (used_words)
);

// File: tb/sim_la_fifo.sv
module sim_la_fifo;

  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int UW    = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr, wr_req, rd_req;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] q_w     [4];
  logic          full_w  [4];
  logic          empty_w [4];
  logic [UW-1:0] used_w  [4];

  int n_chk  = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Mode index: bit1 = show-ahead, bit0 = output register.
  function automatic string empty_tag(input int m);
    case (m)
      0:       return "R4";
      1:       return "R3";
      2:       return "R6";
      default: return "R5";
    endcase
  endfunction

  for (genvar i = 0; i < 4; i++) begin : g_cfg
    localparam bit SA  = ((i / 2) == 1);
    localparam bit ORG = ((i % 2) == 1);
    localparam int LAT = int'(SA) + int'(ORG);

    la_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .SHOW_AHEAD(SA), .OUT_REG(ORG)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .wr_req     (wr_req),
      .wr_data    (wr_data),
      .rd_req     (rd_req),
      .rd_data    (q_w[i]),
      .full       (full_w[i]),
      .empty      (empty_w[i]),
      .used_words (used_w[i])
    );

    // Scoreboard: expected words queued on accepted writes, popped on reads.
    logic [DW-1:0] exp_q [$];
    int            m_cnt = 0;
    int            m_rdy = 0;
    int            wpipe [3] = '{0, 0, 0};
    bit            pend  = 1'b0;
    logic [DW-1:0] pval  = '0;

    always @(negedge clk) begin
      if (mon_on) begin
        int wa, ra;
        chk(int'(used_w[i]) == m_cnt, "R1", "used_words", int'(used_w[i]), m_cnt);
        chk(full_w[i] == (m_cnt == DEPTH), "R2", "full", int'(full_w[i]), int'(m_cnt == DEPTH));
        chk(empty_w[i] == (m_rdy == 0), empty_tag(i), "empty", int'(empty_w[i]), int'(m_rdy == 0));
        if (pend) begin
          chk(q_w[i] == pval, "R7", "popped word", int'(q_w[i]), int'(pval));
          pend = 1'b0;
        end
        if (SA && !empty_w[i] && exp_q.size() > 0)
          chk(q_w[i] == exp_q[0], "R8", "head word", int'(q_w[i]), int'(exp_q[0]));
        wa = int'(wr_req && !full_w[i] && !clr);
        ra = int'(rd_req && !empty_w[i] && !clr);
        if (clr) begin
          exp_q.delete();
          m_cnt = 0;
          m_rdy = 0;
          wpipe = '{0, 0, 0};
        end else begin
          if (ra != 0 && exp_q.size() > 0) begin
            pval = exp_q.pop_front();
            pend = !SA;
          end
          if (wa != 0) exp_q.push_back(wr_data);
          m_cnt = m_cnt + wa - ra;
          wpipe[2] = wpipe[1];
          wpipe[1] = wpipe[0];
          wpipe[0] = wa;
          m_rdy = m_rdy + wpipe[LAT] - ra;
        end
      end
    end
  end

  task automatic drive(input bit w, input logic [DW-1:0] d, input bit r, input bit c);
    wr_req  = w;
    wr_data = d;
    rd_req  = r;
    clr     = c;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] dv;
    logic [DW-1:0] q_hold [4];
    dv      = 8'h10;
    rst_n   = 1'b0;
    clr     = 1'b0;
    wr_req  = 1'b0;
    rd_req  = 1'b0;
    wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R12: reset state in every configuration
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(empty_w[i] == 1'b1, "R12", "empty after reset", int'(empty_w[i]), 1);
      chk(full_w[i] == 1'b0, "R12", "full after reset", int'(full_w[i]), 0);
      chk(used_w[i] == '0, "R12", "used after reset", int'(used_w[i]), 0);
      chk(q_w[i] == '0, "R12", "rd_data after reset", int'(q_w[i]), 0);
    end
    @(posedge clk);
    #1 mon_on = 1'b1;

    // Single write into empty buffer: empty latency R3..R6, then one read
    drive(1'b1, dv, 1'b0, 1'b0); dv++;
    idle(5);
    drive(1'b0, '0, 1'b1, 1'b0);
    idle(3);

    // Fill past capacity: R9
    for (int k = 0; k < DEPTH + 2; k++) begin
      drive(1'b1, dv, 1'b0, 1'b0);
      dv++;
    end
    idle(3);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(used_w[i] == UW'(DEPTH), "R9", "used after overflow", int'(used_w[i]), DEPTH);
      chk(full_w[i] == 1'b1, "R9", "full after overflow", int'(full_w[i]), 1);
    end
    @(posedge clk);
    #1;

    // Drain with extra reads: order R8, then read on empty R10
    for (int k = 0; k < DEPTH + 3; k++) drive(1'b0, '0, 1'b1, 1'b0);
    idle(4);
    @(negedge clk);
    for (int i = 0; i < 4; i++) q_hold[i] = q_w[i];
    @(posedge clk);
    #1;
    drive(1'b0, '0, 1'b1, 1'b0);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(q_w[i] == q_hold[i], "R10", "rd_data on empty read", int'(q_w[i]), int'(q_hold[i]));
      chk(used_w[i] == '0, "R10", "used on empty read", int'(used_w[i]), 0);
    end
    @(posedge clk);
    #1;
    idle(2);

    // Mixed traffic: write-heavy phase then read-heavy phase
    for (int k = 0; k < 300; k++) begin
      bit w, r;
      w = ($urandom % 4) != 0;
      r = ($urandom % 3) == 0;
      drive(w, dv, r, 1'b0);
      dv++;
    end
    for (int k = 0; k < 300; k++) begin
      bit w, r;
      w = ($urandom % 3) == 0;
      r = ($urandom % 4) != 0;
      drive(w, dv, r, 1'b0);
      dv++;
    end
    idle(4);

    // Flush with simultaneous requests: R11
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, dv, 1'b0, 1'b0);
      dv++;
    end
    idle(3);
    drive(1'b1, dv, 1'b1, 1'b1);
    dv++;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(empty_w[i] == 1'b1, "R11", "empty after clr", int'(empty_w[i]), 1);
      chk(full_w[i] == 1'b0, "R11", "full after clr", int'(full_w[i]), 0);
      chk(used_w[i] == '0, "R11", "used after clr", int'(used_w[i]), 0);
      chk(q_w[i] == '0, "R11", "rd_data after clr", int'(q_w[i]), 0);
    end
    @(posedge clk);
    #1;

    // Traffic after the flush restarts cleanly
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, dv, 1'b0, 1'b0);
      dv++;
    end
    idle(4);
    for (int k = 0; k < 4; k++) drive(1'b0, '0, 1'b1, 1'b0);
    idle(5);

    summary();
    $finish;
  end

endmodule